// File: doc/BRIEF.md
# Bank-Zero Address Decoder with Overlay Windows

This block turns a 24-bit processor address into one chip select for the memory or peripheral that owns that address. The selectable targets are base RAM, extended RAM, a low ROM, a high ROM, eight 256-byte peripheral pages and an internal management register page. Bank zero has a fixed layout. Three overlay controls, driven by the management registers, can put a different device into three of its windows. With the low-ROM overlay set, ROM appears at `$00C000`–`$00CFFF`. With the I/O overlay set, RAM replaces the peripheral pages. With the high-RAM overlay set, RAM replaces the high ROM at `$00E000`–`$00FFFF`. When all three controls are low, the high ROM holds the top of bank zero, so the processor can fetch its reset vectors from it.

The block also drives the active-low read strobe and a ready line for the processor. Accesses to ROM or to a peripheral page are stretched by one wait state. RAM and the management page run without wait states.

The clock `clk` marks one processor bus cycle per rising edge. The address is held steady for as long as `rdy` is low. Reset is asserted asynchronously and released through a two-stage synchronizer. Every select stays inactive until that synchronizer has released.

Top module: `bank_decoder`

## Requirements
- R1: Addresses `$000000`–`$00BFFF` and `$00D800`–`$00DEFF` assert `bram_cs_n` and no other select.
- R2: Addresses `$010000`–`$0FFFFF` assert `xram_cs_n`.
- R3: In `$00C000`–`$00CFFF`, `lrom_cs_n` is asserted when `ovl_lorom` is 1. When `ovl_lorom` is 0, `bram_cs_n` is asserted instead.
- R4: In `$00D000`–`$00D7FF` with `ovl_ioram` at 0, `io_cs_n[k]` is asserted, where k is address bits 10:8. With `ovl_ioram` at 1, `bram_cs_n` is asserted instead.
- R5: Addresses `$00DF00`–`$00DFFF` assert `mgmt_cs_n`.
- R6: In `$00E000`–`$00FFFF`, `hrom_cs_n` is asserted when `ovl_hiram` is 0. When `ovl_hiram` is 1, `bram_cs_n` is asserted instead.
- R7: Addresses `$100000` and above assert no select.
- R8: At most one of the active-low selects is low at any time.
- R9: While `rst_n` is low, and up to the second rising `clk` edge after it goes high, all selects and `rd_n` are high and `rdy` is high.
- R10: Outside reset, `rd_n` is low exactly when `rwb` is 1 and `phi2` is 1.
- R11: An access to low ROM, high ROM or a peripheral page holds `rdy` low in its first cycle and high in the following cycle at the same address. RAM and management accesses keep `rdy` high.
- R12: Back-to-back slow accesses to different addresses each get exactly one wait cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 24 | Processor address |
| rwb | input | 1 | 1 = read, 0 = write |
| phi2 | input | 1 | Phase-2 clock level |
| ovl_lorom | input | 1 | 1 maps low ROM at `$00C000` |
| ovl_ioram | input | 1 | 1 maps RAM over the peripheral pages |
| ovl_hiram | input | 1 | 1 maps RAM over the high ROM |
| bram_cs_n | output | 1 | Base RAM select (also the bank-zero RAM overlays) |
| xram_cs_n | output | 1 | Extended RAM select |
| lrom_cs_n | output | 1 | Low ROM select |
| hrom_cs_n | output | 1 | High ROM select |
| mgmt_cs_n | output | 1 | Management register page select |
| io_cs_n | output | 8 | Peripheral page selects, one per 256-byte page |
| rd_n | output | 1 | Active-low read strobe |
| rdy | output | 1 | Ready; low inserts a wait state |

## Verification
The checker evaluates a set of cycle-level invariants on every clock edge:
- At most one select is active at a time.
- Nothing is selected above `$0FFFFF`.
- The read strobe follows `rwb` and `phi2`.
- Every low `rdy` is followed by a high one, and `rdy` goes low only while a ROM or peripheral page is selected.
- Everything is idle while reset is asserted.

Only the bench scenarios can show that each window reaches the correct device under each overlay setting. They also show the page index within the I/O block, the two-edge reset release, and that consecutive slow accesses each receive exactly one wait cycle.

// File: rtl/bank_decoder_pkg.sv
package bank_decoder_pkg;

  typedef enum logic [2:0] {
    RG_NONE = 3'd0,
    RG_BRAM = 3'd1,
    RG_XRAM = 3'd2,
    RG_LROM = 3'd3,
    RG_HROM = 3'd4,
    RG_IO   = 3'd5,
    RG_MGMT = 3'd6
  } region_e;

  // bank-zero window boundaries (16-bit offsets within bank zero)
  localparam logic [15:0] LROM_BASE = 16'hC000;
  localparam logic [15:0] IO_BASE   = 16'hD000;
  localparam logic [15:0] PROT_BASE = 16'hD800;
  localparam logic [15:0] MGMT_BASE = 16'hDF00;
  localparam logic [15:0] HROM_BASE = 16'hE000;

  // first address above extended RAM
  localparam logic [23:0] XRAM_LIMIT = 24'h100000;

  // size of one peripheral page in address bits
  localparam int unsigned IO_PAGE_W = 8;

endpackage

// File: rtl/bank_rst_sync.sv
module bank_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/bank_region_decode.sv
module bank_region_decode
  import bank_decoder_pkg::*;
#(
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned IO_DEVS  = 8,
  localparam int unsigned IO_IDX_W = (IO_DEVS > 1) ? $clog2(IO_DEVS) : 1
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic                ovl_lorom,
  input  logic                ovl_ioram,
  input  logic                ovl_hiram,
  output region_e             region,
  output logic [IO_IDX_W-1:0] io_idx,
  output logic                slow
);
  logic [15:0]       offs;
  logic [ADDR_W-17:0] bank;

  always_comb begin
    offs   = addr[15:0];
    bank   = addr[ADDR_W-1:16];
    region = RG_NONE;
    if (bank == '0) begin
      if (offs < LROM_BASE) begin
        region = RG_BRAM;
      end else if (offs < IO_BASE) begin
        region = ovl_lorom ? RG_LROM : RG_BRAM;
      end else if (offs < PROT_BASE) begin
        region = ovl_ioram ? RG_BRAM : RG_IO;
      end else if (offs < MGMT_BASE) begin
        region = RG_BRAM;
      end else if (offs < HROM_BASE) begin
        region = RG_MGMT;
      end else begin
        region = ovl_hiram ? RG_BRAM : RG_HROM;
      end
    end else if (addr < XRAM_LIMIT) begin
      region = RG_XRAM;
    end
  end

  assign io_idx = addr[IO_PAGE_W +: IO_IDX_W];
  assign slow   = (region == RG_LROM) || (region == RG_HROM) || (region == RG_IO);
endmodule

// File: rtl/bank_select_drive.sv
module bank_select_drive
  import bank_decoder_pkg::*;
#(
  parameter int unsigned IO_DEVS  = 8,
  localparam int unsigned IO_IDX_W = (IO_DEVS > 1) ? $clog2(IO_DEVS) : 1
) (
  input  logic                en,
  input  region_e             region,
  input  logic [IO_IDX_W-1:0] io_idx,
  output logic                bram_cs_n,
  output logic                xram_cs_n,
  output logic                lrom_cs_n,
  output logic                hrom_cs_n,
  output logic                mgmt_cs_n,
  output logic [IO_DEVS-1:0]  io_cs_n
);
  assign bram_cs_n = !(en && region == RG_BRAM);
  assign xram_cs_n = !(en && region == RG_XRAM);
  assign lrom_cs_n = !(en && region == RG_LROM);
  assign hrom_cs_n = !(en && region == RG_HROM);
  assign mgmt_cs_n = !(en && region == RG_MGMT);

  for (genvar g = 0; g < IO_DEVS; g++) begin : g_io
    assign io_cs_n[g] = !(en && region == RG_IO && io_idx == IO_IDX_W'(g));
  end
endmodule

// File: rtl/bank_wait_gen.sv
module bank_wait_gen #(
  parameter int unsigned WAIT_STATES = 1,
  localparam int unsigned CNT_W = $clog2(WAIT_STATES + 1)
) (
  input  logic clk,
  input  logic srst_n,
  input  logic slow,
  output logic rdy
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             stall;

  always_comb begin
    stall  = slow && (cnt_q < CNT_W'(WAIT_STATES));
    cnt_d  = stall ? cnt_q + CNT_W'(1) : '0;
    cnt_en = slow || (cnt_q != '0);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign rdy = !stall;
endmodule

// File: rtl/bank_decoder.sv
module bank_decoder
  import bank_decoder_pkg::*;
#(
  parameter int unsigned ADDR_W      = 24,
  parameter int unsigned IO_DEVS     = 8,
  parameter int unsigned WAIT_STATES = 1,
  localparam int unsigned IO_IDX_W   = (IO_DEVS > 1) ? $clog2(IO_DEVS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               rwb,
  input  logic               phi2,
  input  logic               ovl_lorom,
  input  logic               ovl_ioram,
  input  logic               ovl_hiram,
  output logic               bram_cs_n,
  output logic               xram_cs_n,
  output logic               lrom_cs_n,
  output logic               hrom_cs_n,
  output logic               mgmt_cs_n,
  output logic [IO_DEVS-1:0] io_cs_n,
  output logic               rd_n,
  output logic               rdy
);
  logic                sys_rst_n;
  region_e             region;
  logic [IO_IDX_W-1:0] io_idx;
  logic                slow_raw;

  bank_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (sys_rst_n)
  );

  bank_region_decode #(
    .ADDR_W  (ADDR_W),
    .IO_DEVS (IO_DEVS)
  ) u_dec (
    .addr      (addr),
    .ovl_lorom (ovl_lorom),
    .ovl_ioram (ovl_ioram),
    .ovl_hiram (ovl_hiram),
    .region    (region),
    .io_idx    (io_idx),
    .slow      (slow_raw)
  );

  bank_select_drive #(
    .IO_DEVS (IO_DEVS)
  ) u_sel (
    .en        (sys_rst_n),
    .region    (region),
    .io_idx    (io_idx),
    .bram_cs_n (bram_cs_n),
    .xram_cs_n (xram_cs_n),
    .lrom_cs_n (lrom_cs_n),
    .hrom_cs_n (hrom_cs_n),
    .mgmt_cs_n (mgmt_cs_n),
    .io_cs_n   (io_cs_n)
  );

  bank_wait_gen #(
    .WAIT_STATES (WAIT_STATES)
  ) u_wait (
    .clk    (clk),
    .srst_n (sys_rst_n),
    .slow   (slow_raw && sys_rst_n),
    .rdy    (rdy)
  );

  assign rd_n = !(sys_rst_n && rwb && phi2);
endmodule

// File: rtl/bank_decoder_chk.sv
module bank_decoder_chk #(
  parameter int unsigned ADDR_W  = 24,
  parameter int unsigned IO_DEVS = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               srst_n,
  input logic [ADDR_W-1:0]  addr,
  input logic               rwb,
  input logic               phi2,
  input logic               bram_cs_n,
  input logic               xram_cs_n,
  input logic               lrom_cs_n,
  input logic               hrom_cs_n,
  input logic               mgmt_cs_n,
  input logic [IO_DEVS-1:0] io_cs_n,
  input logic               rd_n,
  input logic               rdy
);
  logic [IO_DEVS+4:0] sel_n;
  assign sel_n = {bram_cs_n, xram_cs_n, lrom_cs_n, hrom_cs_n, mgmt_cs_n, io_cs_n};

  // R8
  one_select_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $onehot0(~sel_n));

  // R7
  above_map_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (addr >= ADDR_W'(24'h100000)) |-> (&sel_n));

  // R10
  rd_low_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (rwb && phi2) |-> !rd_n);

  // R10
  rd_high_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !(rwb && phi2) |-> rd_n);

  // R11
  wait_one_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !rdy |=> rdy);

  // R11
  wait_src_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !rdy |-> (!lrom_cs_n || !hrom_cs_n || !(&io_cs_n)));

  // R9
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |-> ((&sel_n) && rd_n && rdy));
endmodule

bind bank_decoder bank_decoder_chk #(
  .ADDR_W  (ADDR_W),
  .IO_DEVS (IO_DEVS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .srst_n    (sys_rst_n),
  .addr      (addr),
  .rwb       (rwb),
  .phi2      (phi2),
  .bram_cs_n (bram_cs_n),
  .xram_cs_n (xram_cs_n),
  .lrom_cs_n (lrom_cs_n),
  .hrom_cs_n (hrom_cs_n),
  .mgmt_cs_n (mgmt_cs_n),
  .io_cs_n   (io_cs_n),
  .rd_n      (rd_n),
  .rdy       (rdy)
);

// File: tb/bank_decoder_test.sv
module bank_decoder_test;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [23:0] addr;
  logic        rwb;
  logic        phi2;
  logic        ovl_lorom;
  logic        ovl_ioram;
  logic        ovl_hiram;
  logic        bram_cs_n;
  logic        xram_cs_n;
  logic        lrom_cs_n;
  logic        hrom_cs_n;
  logic        mgmt_cs_n;
  logic [7:0]  io_cs_n;
  logic        rd_n;
  logic        rdy;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // behavioural model state
  int rel_edges = 0;   // rising edges seen since rst_n went high
  int pending   = 0;   // 1 when the wait cycle for the current access was served

  bank_decoder uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .rwb       (rwb),
    .phi2      (phi2),
    .ovl_lorom (ovl_lorom),
    .ovl_ioram (ovl_ioram),
    .ovl_hiram (ovl_hiram),
    .bram_cs_n (bram_cs_n),
    .xram_cs_n (xram_cs_n),
    .lrom_cs_n (lrom_cs_n),
    .hrom_cs_n (hrom_cs_n),
    .mgmt_cs_n (mgmt_cs_n),
    .io_cs_n   (io_cs_n),
    .rd_n      (rd_n),
    .rdy       (rdy)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // expected selects, packed {bram,xram,lrom,hrom,mgmt,io[7:0]}, active low
  function automatic logic [12:0] model_sel(input logic [23:0] a);
    logic [12:0] v;
    int x;
    v = '1;
    x = int'(a);
    if (x >= 'h100000) begin
      v = '1;
    end else if (x >= 'h10000) begin
      v[11] = 1'b0;
    end else if (x >= 'hE000) begin
      if (ovl_hiram) v[12] = 1'b0; else v[9] = 1'b0;
    end else if (x >= 'hDF00) begin
      v[8] = 1'b0;
    end else if (x >= 'hD800) begin
      v[12] = 1'b0;
    end else if (x >= 'hD000) begin
      if (ovl_ioram) v[12] = 1'b0; else v[(x - 'hD000) / 256] = 1'b0;
    end else if (x >= 'hC000) begin
      if (ovl_lorom) v[10] = 1'b0; else v[12] = 1'b0;
    end else begin
      v[12] = 1'b0;
    end
    return v;
  endfunction

  function automatic bit is_slow(input logic [12:0] v);
    return (v[10] == 1'b0) || (v[9] == 1'b0) || (v[7:0] != 8'hFF);
  endfunction

  task automatic check(input string req, input logic [12:0] act, input logic [12:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, addr, act, exp);
    end
  endtask

  // one bus cycle: drive, compare against the model, advance the model one edge
  task automatic bus(input logic [23:0] a, input logic rw, input logic p2,
                     input string stag, input string rtag);
    logic [12:0] act;
    logic [12:0] exp_sel;
    bit          idle;
    bit          slow;
    bit          exp_rdy;
    addr = a;
    rwb  = rw;
    phi2 = p2;
    #(CLK_PERIOD/4);
    idle    = !rst_n || (rel_edges < 2);
    exp_sel = idle ? '1 : model_sel(a);
    slow    = !idle && is_slow(exp_sel);
    exp_rdy = !(slow && pending == 0);
    act     = {bram_cs_n, xram_cs_n, lrom_cs_n, hrom_cs_n, mgmt_cs_n, io_cs_n};
    check(idle ? "R9" : stag, act, exp_sel);
    check("R8", 13'($countones(~act) <= 1), 13'd1);
    check(idle ? "R9" : "R10", 13'(rd_n), 13'(idle ? 1'b1 : !(rw && p2)));
    check(idle ? "R9" : rtag, 13'(rdy), 13'(exp_rdy));
    @(posedge clk);
    if (!rst_n) rel_edges = 0;
    else if (rel_edges < 2) rel_edges++;
    pending = (slow && pending == 0) ? 1 : 0;
    @(negedge clk);
  endtask

  // a complete access: a slow target is held for its wait cycle
  task automatic access(input logic [23:0] a, input string stag);
    bit slow;
    slow = is_slow(model_sel(a));
    bus(a, 1'b1, 1'b1, stag, "R11");
    if (slow) bus(a, 1'b1, 1'b1, stag, "R11");
  endtask

  initial begin
    rst_n = 1'b0; addr = '0; rwb = 1'b0; phi2 = 1'b0;
    ovl_lorom = 1'b0; ovl_ioram = 1'b0; ovl_hiram = 1'b0;
    @(negedge clk);
    // R9 reset state, then two-edge release
    for (int i = 0; i < 3; i++) bus(24'h00E000, 1'b1, 1'b1, "R9", "R9");
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) bus(24'h00FFFC, 1'b1, 1'b1, "R6", "R11");

    // R1
    access(24'h000000, "R1"); access(24'h00BFFF, "R1");
    access(24'h00D800, "R1"); access(24'h00DEFF, "R1");
    // R2
    access(24'h010000, "R2"); access(24'h0FFFFF, "R2"); access(24'h05A5A5, "R2");
    // R3
    access(24'h00C000, "R3"); access(24'h00CFFF, "R3");
    ovl_lorom = 1'b1;
    access(24'h00C000, "R3"); access(24'h00CFFF, "R3");
    ovl_lorom = 1'b0;
    // R4 every page, then RAM overlay
    for (int k = 0; k < 8; k++) access(24'h00D000 + 24'(k * 256 + k * 17), "R4");
    ovl_ioram = 1'b1;
    access(24'h00D000, "R4"); access(24'h00D7FF, "R4");
    ovl_ioram = 1'b0;
    // R5
    access(24'h00DF00, "R5"); access(24'h00DFFF, "R5");
    // R6
    access(24'h00E000, "R6"); access(24'h00FFFC, "R6");
    ovl_hiram = 1'b1;
    access(24'h00FFFC, "R6"); access(24'h00E000, "R6");
    ovl_hiram = 1'b0;
    // R7
    access(24'h100000, "R7"); access(24'hFFFFFF, "R7"); access(24'h800000, "R7");
    // R10 strobe combinations
    bus(24'h000100, 1'b0, 1'b0, "R10", "R11");
    bus(24'h000100, 1'b0, 1'b1, "R10", "R11");
    bus(24'h000100, 1'b1, 1'b0, "R10", "R11");
    bus(24'h000100, 1'b1, 1'b1, "R10", "R11");
    // R12 consecutive slow accesses, writes included
    bus(24'h00E000, 1'b0, 1'b1, "R12", "R12");
    bus(24'h00E000, 1'b0, 1'b1, "R12", "R12");
    bus(24'h00D100, 1'b1, 1'b1, "R12", "R12");
    bus(24'h00D100, 1'b1, 1'b1, "R12", "R12");
    bus(24'h00C800, 1'b1, 1'b1, "R12", "R12");
    bus(24'h00F000, 1'b1, 1'b1, "R12", "R12");
    bus(24'h00F000, 1'b1, 1'b1, "R12", "R12");
    // R9 reset again mid-run
    rst_n = 1'b0;
    for (int i = 0; i < 3; i++) bus(24'h00D300, 1'b1, 1'b1, "R9", "R9");
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) bus(24'h00D300, 1'b1, 1'b1, "R4", "R11");
    access(24'h000042, "R1");

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule